// File: doc/BRIEF.md
# Host Cached-Length Transfer Scheduler

This block sits on the host side of a half-duplex serial link to a co-processor. It runs data transfers once the link is up. The co-processor publishes two free-running cumulative counters. The first is a transmit byte count, which says how much it has queued for the host. The second is a receive buffer count, which says how many buffers it has freed for the host. The scheduler keeps a local copy of each counter. The amount to move is always the modulo difference between a fresh reading and that copy.

A read job starts when the co-processor raises its data-ready line. The scheduler fetches the transmit counter and derives the byte count. It then acknowledges the register read, streams the bytes with a DMA read, and closes the DMA read. A write job starts when the local payload side requests a number of buffers. The scheduler polls the receive counter until enough buffers are free. It then sends each buffer as a DMA write followed by a write-completion command.

The scheduler issues commands to an SPI master through a valid/ready port. A command carries an opcode, a register address and a length. Register-read results return on a one-cycle response strobe. Lane-width masking, SPI signalling and framing belong to the master.

Top module: `xfer_sched`

## Requirements
- R1: After reset, cmd_valid, rd_done and wr_done are low and both cached counters are zero. The first read therefore reports the full masked transmit count.
- R2: With data_ready high in idle, the first command is a register read (op 0x02) of address 0x0C with length 0.
- R3: Only the low LEN_W bits of the response are used. The upper REG_W-LEN_W bits have no effect on any length.
- R4: The read byte count equals the masked transmit count minus the cached transmit count, modulo 2^LEN_W. It holds across counter wrap-around and appears on rd_bytes with rd_done.
- R5: After the response, the command sequence is op 0x09, then op 0x04 with the byte count as length, then op 0x08. The cached transmit count then takes the value read. rd_done pulses for one cycle, starting the cycle after op 0x08 is accepted.
- R6: A zero byte count sends op 0x09 only, with no op 0x04 or 0x08, then pulses rd_done with rd_bytes 0.
- R7: A write job reads address 0x10 with op 0x02. The free buffer count is the reading minus the cached receive count, modulo 2^LEN_W. The register is read again until the free count is at least wr_nbuf.
- R8: Once enough buffers are free, wr_nbuf pairs are sent. Each pair is op 0x03 with length max_rx_len, then op 0x07. The cached receive count then grows by wr_nbuf, and wr_done pulses for one cycle after the last op 0x07 is accepted.
- R9: When data_ready and wr_req are both high in idle, the read job is served first.
- R10: While cmd_valid is high and cmd_ready is low, the command's opcode, address and length do not change.
- R11: rd_done and wr_done are never high together, and no command is offered in a cycle where either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_ready | input | 1 | Co-processor has data for the host |
| wr_req | input | 1 | Write job pending, held until wr_done |
| wr_nbuf | input | NBUF_W | Buffers in the write job |
| max_rx_len | input | LEN_W | Bytes per co-processor receive buffer |
| cmd_valid | output | 1 | Command offered to the SPI master |
| cmd_ready | input | 1 | SPI master accepts the command |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | 8 | Register address for register reads, else 0 |
| cmd_len | output | LEN_W | DMA length, else 0 |
| rsp_valid | input | 1 | Register-read result strobe |
| rsp_data | input | REG_W | Register-read result |
| rd_done | output | 1 | Read job finished (one cycle) |
| rd_bytes | output | LEN_W | Bytes moved by the finished read job |
| wr_done | output | 1 | Write job finished (one cycle) |

## Verification
The assertions assume a well-behaved SPI master. It returns exactly one response strobe per accepted register read, and only after that read is accepted. They also assume that data_ready drops once op 0x09 is accepted, and that wr_req, wr_nbuf and max_rx_len stay stable until wr_done. The bench's master model is a set of sequential tasks that answer one command at a time. Each response is driven only after the read is accepted, and data_ready and wr_req are released at exactly those points. The bench also stalls cmd_ready on some commands to exercise hold behaviour.

// File: rtl/xfer_sched_pkg.sv
package xfer_sched_pkg;
   localparam logic [7:0] OP_REG_RD   = 8'h02;
   localparam logic [7:0] OP_DMA_WR   = 8'h03;
   localparam logic [7:0] OP_DMA_RD   = 8'h04;
   localparam logic [7:0] OP_WR_CLOSE = 8'h07;
   localparam logic [7:0] OP_RD_CLOSE = 8'h08;
   localparam logic [7:0] OP_REG_ACK  = 8'h09;
   localparam logic [7:0] ADR_TXCNT   = 8'h0C;
   localparam logic [7:0] ADR_RXCNT   = 8'h10;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RREQ, ST_RWAIT, ST_RACK, ST_RDMA, ST_REND,
      ST_WREQ, ST_WWAIT, ST_WCHK, ST_WDMA, ST_WEND
   } sched_st_t;
endpackage

// File: rtl/len_delta.sv
module len_delta #(
   parameter int LEN_W = 24,
   parameter int IN_W  = 32
) (
   input  logic [IN_W-1:0]  raw,
   input  logic [LEN_W-1:0] cached,
   output logic [LEN_W-1:0] masked,
   output logic [LEN_W-1:0] delta
);
   if (LEN_W < 2) begin : g_bad_len
      $error("len_delta: LEN_W must be at least 2");
   end

   if (IN_W > LEN_W) begin : g_trim
      assign masked = raw[LEN_W-1:0];
   end else if (IN_W == LEN_W) begin : g_same
      assign masked = raw;
   end else begin : g_pad
      assign masked = {{(LEN_W-IN_W){1'b0}}, raw};
   end

   // modulo 2^LEN_W by width truncation
   assign delta = masked - cached;
endmodule

// File: rtl/len_cache.sv
module len_cache #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/xfer_sched.sv
module xfer_sched
   import xfer_sched_pkg::*;
#(
   parameter int LEN_W  = 24,
   parameter int REG_W  = 32,
   parameter int NBUF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_ready,
   input  logic              wr_req,
   input  logic [NBUF_W-1:0] wr_nbuf,
   input  logic [LEN_W-1:0]  max_rx_len,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [7:0]        cmd_op,
   output logic [7:0]        cmd_addr,
   output logic [LEN_W-1:0]  cmd_len,
   input  logic              rsp_valid,
   input  logic [REG_W-1:0]  rsp_data,
   output logic              rd_done,
   output logic [LEN_W-1:0]  rd_bytes,
   output logic              wr_done
);
   localparam int PAD_W = LEN_W - NBUF_W;

   if (REG_W < LEN_W) begin : g_bad_reg
      $error("xfer_sched: REG_W must be at least LEN_W");
   end
   if (NBUF_W < 1 || NBUF_W >= LEN_W) begin : g_bad_nbuf
      $error("xfer_sched: NBUF_W must lie in 1..LEN_W-1");
   end

   sched_st_t           st;
   logic [REG_W-1:0]    rsp_q;
   logic [NBUF_W-1:0]   nbuf_q;
   logic [NBUF_W-1:0]   left_q;
   logic                rd_done_q, wr_done_q;
   logic [LEN_W-1:0]    rd_bytes_q;
   logic [LEN_W-1:0]    tx_cache, rx_cache;
   logic [LEN_W-1:0]    tx_masked, tx_delta, rx_masked, rx_avail;
   logic                fire, tx_load, rx_load, enough;
   logic [LEN_W-1:0]    nbuf_ext;

   len_delta #(.LEN_W(LEN_W), .IN_W(REG_W)) u_tx_delta (
      .raw(rsp_q), .cached(tx_cache), .masked(tx_masked), .delta(tx_delta));
   len_delta #(.LEN_W(LEN_W), .IN_W(REG_W)) u_rx_delta (
      .raw(rsp_q), .cached(rx_cache), .masked(rx_masked), .delta(rx_avail));

   len_cache #(.W(LEN_W)) u_tx_cache (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .d(tx_masked), .q(tx_cache));
   len_cache #(.W(LEN_W)) u_rx_cache (
      .clk(clk), .rst_n(rst_n), .load(rx_load), .d(rx_cache + nbuf_ext), .q(rx_cache));

   assign nbuf_ext = {{PAD_W{1'b0}}, nbuf_q};
   assign enough   = (rx_avail >= nbuf_ext);
   assign fire     = cmd_valid & cmd_ready;
   assign tx_load  = fire & ((st == ST_REND) | ((st == ST_RACK) & (tx_delta == '0)));
   assign rx_load  = ((st == ST_WCHK) & enough & (nbuf_q == '0))
                   | (fire & (st == ST_WEND) & (left_q == NBUF_W'(1)));

   always_comb begin
      cmd_valid = 1'b1;
      cmd_op    = 8'h00;
      cmd_addr  = 8'h00;
      cmd_len   = '0;
      case (st)
         ST_RREQ: begin cmd_op = OP_REG_RD; cmd_addr = ADR_TXCNT; end
         ST_RACK: cmd_op = OP_REG_ACK;
         ST_RDMA: begin cmd_op = OP_DMA_RD; cmd_len = tx_delta; end
         ST_REND: cmd_op = OP_RD_CLOSE;
         ST_WREQ: begin cmd_op = OP_REG_RD; cmd_addr = ADR_RXCNT; end
         ST_WDMA: begin cmd_op = OP_DMA_WR; cmd_len = max_rx_len; end
         ST_WEND: cmd_op = OP_WR_CLOSE;
         default: cmd_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         rsp_q      <= '0;
         nbuf_q     <= '0;
         left_q     <= '0;
         rd_done_q  <= 1'b0;
         wr_done_q  <= 1'b0;
         rd_bytes_q <= '0;
      end else begin
         rd_done_q <= 1'b0;
         wr_done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (data_ready) st <= ST_RREQ;
               else if (wr_req) begin
                  st     <= ST_WREQ;
                  nbuf_q <= wr_nbuf;
               end
            end
            ST_RREQ:  if (fire) st <= ST_RWAIT;
            ST_RWAIT: if (rsp_valid) begin
               rsp_q <= rsp_data;
               st    <= ST_RACK;
            end
            ST_RACK: if (fire) begin
               if (tx_delta == '0) begin
                  st         <= ST_IDLE;
                  rd_done_q  <= 1'b1;
                  rd_bytes_q <= '0;
               end else st <= ST_RDMA;
            end
            ST_RDMA: if (fire) st <= ST_REND;
            ST_REND: if (fire) begin
               st         <= ST_IDLE;
               rd_done_q  <= 1'b1;
               rd_bytes_q <= tx_delta;
            end
            ST_WREQ:  if (fire) st <= ST_WWAIT;
            ST_WWAIT: if (rsp_valid) begin
               rsp_q <= rsp_data;
               st    <= ST_WCHK;
            end
            ST_WCHK: begin
               if (!enough) st <= ST_WREQ;
               else if (nbuf_q == '0) begin
                  st        <= ST_IDLE;
                  wr_done_q <= 1'b1;
               end else begin
                  st     <= ST_WDMA;
                  left_q <= nbuf_q;
               end
            end
            ST_WDMA: if (fire) st <= ST_WEND;
            ST_WEND: if (fire) begin
               if (left_q == NBUF_W'(1)) begin
                  st        <= ST_IDLE;
                  wr_done_q <= 1'b1;
               end else begin
                  st     <= ST_WDMA;
                  left_q <= left_q - NBUF_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_done  = rd_done_q;
   assign wr_done  = wr_done_q;
   assign rd_bytes = rd_bytes_q;

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len)));
   // R11
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_done && wr_done));
   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done || wr_done) |-> !cmd_valid);
   // R6
   no_empty_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_DMA_RD) |-> (cmd_len != '0));
   // R8
   buf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_DMA_WR) |-> (cmd_len == max_rx_len));
   // R5
   tx_cache_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_done) |-> (tx_cache == tx_masked));
endmodule

// File: tb/sim_xfer_sched.sv
`timescale 1ns/1ps
module sim_xfer_sched;
   localparam int LW = 24;
   localparam int RW = 32;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          data_ready = 1'b0, wr_req = 1'b0;
   logic [NW-1:0] wr_nbuf = '0;
   logic [LW-1:0] max_rx_len = 24'h40;
   logic          cmd_valid, cmd_ready = 1'b0;
   logic [7:0]    cmd_op, cmd_addr;
   logic [LW-1:0] cmd_len;
   logic          rsp_valid = 1'b0;
   logic [RW-1:0] rsp_data = '0;
   logic          rd_done, wr_done;
   logic [LW-1:0] rd_bytes;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;
   logic [LW-1:0] txc = '0, rxc = '0;

   always #4 clk = ~clk;

   xfer_sched #(.LEN_W(LW), .REG_W(RW), .NBUF_W(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .data_ready(data_ready), .wr_req(wr_req),
      .wr_nbuf(wr_nbuf), .max_rx_len(max_rx_len), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rd_done(rd_done), .rd_bytes(rd_bytes), .wr_done(wr_done));

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic expect_cmd(input logic [7:0] op, input logic [7:0] ad,
                             input logic [LW-1:0] ln, input string tag, input int stall);
      int w = 0;
      while (!cmd_valid && w < 200) begin @(negedge clk); w++; end
      chk(cmd_valid, tag, "cmd_valid", cmd_valid, 1);
      chk(cmd_op == op && cmd_addr == ad && cmd_len == ln, tag, "op/addr/len",
          {cmd_op, cmd_addr, cmd_len}, {op, ad, ln});
      for (int s = 0; s < stall; s++) @(negedge clk);
      if (stall > 0)
         chk(cmd_valid && cmd_op == op && cmd_addr == ad && cmd_len == ln, "R10",
             "held command", {cmd_op, cmd_addr, cmd_len}, {op, ad, ln});
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic give_rsp(input logic [RW-1:0] d);
      rsp_data  = d;
      rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic do_read(input logic [LW-1:0] val, input logic [7:0] upper, input int stall);
      logic [LW-1:0] exp = val - txc;
      data_ready = 1'b1;
      expect_cmd(8'h02, 8'h0C, '0, "R2", stall);
      give_rsp({upper, val});
      expect_cmd(8'h09, 8'h00, '0, "R5", 0);
      data_ready = 1'b0;
      if (exp != '0) begin
         expect_cmd(8'h04, 8'h00, exp, "R4", stall);
         expect_cmd(8'h08, 8'h00, '0, "R5", 0);
         chk(rd_done && rd_bytes == exp, "R4", "rd_done/rd_bytes", {rd_done, rd_bytes}, {1'b1, exp});
      end else begin
         chk(rd_done && rd_bytes == '0 && !cmd_valid, "R6", "zero skip",
             {rd_done, rd_bytes, cmd_valid}, {1'b1, 24'h0, 1'b0});
      end
      txc = val;
      @(negedge clk);
      chk(!rd_done, "R5", "rd_done one cycle", rd_done, 0);
   endtask

   task automatic poll_rx(input logic [LW-1:0] val);
      expect_cmd(8'h02, 8'h10, '0, "R7", 0);
      give_rsp({8'hA5, val});
   endtask

   task automatic send_bufs(input int n);
      for (int b = 0; b < n; b++) begin
         expect_cmd(8'h03, 8'h00, max_rx_len, "R8", (b == 1) ? 2 : 0);
         expect_cmd(8'h07, 8'h00, '0, "R8", 0);
      end
      chk(wr_done && !rd_done, "R8", "wr_done", {wr_done, rd_done}, 2'b10);
      wr_req = 1'b0;
      rxc = rxc + LW'(n);
      @(negedge clk);
      chk(!wr_done && !cmd_valid, "R11", "idle after write", {wr_done, cmd_valid}, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         fails++;
         checks++;
         $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!cmd_valid && !rd_done && !wr_done, "R1", "reset outputs",
          {cmd_valid, rd_done, wr_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!cmd_valid, "R1", "idle without requests", cmd_valid, 0);

      // R1/R3/R4: first read reports the full count, upper bits ignored
      do_read(24'h000123, 8'hFF, 0);
      // R6: zero difference
      do_read(24'h000123, 8'h3C, 0);
      // R4/R3: sweep including counter wrap
      for (int i = 1; i <= 8; i++)
         do_read(LW'(i * 32'h300000 + i * 7), 8'(i * 8'h11), i % 3);
      do_read(24'hFFFFF0, 8'h00, 0);
      do_read(24'h000010, 8'hEE, 1);

      // R7/R8: writes, insufficient then sufficient
      for (int n = 1; n <= 4; n++) begin
         if (n == 3) max_rx_len = 24'h123;
         wr_nbuf = NW'(n);
         wr_req  = 1'b1;
         poll_rx(rxc + LW'(n - 1));
         poll_rx(rxc + LW'(n - 1));
         poll_rx(rxc + LW'(n + n % 2));
         send_bufs(n);
      end
      // R8: zero-buffer job completes without DMA
      wr_nbuf = '0;
      wr_req  = 1'b1;
      poll_rx(rxc);
      @(negedge clk);
      chk(wr_done && !cmd_valid, "R8", "empty write job", {wr_done, cmd_valid}, 2'b10);
      wr_req = 1'b0;
      @(negedge clk);

      // R9: read served before write
      wr_nbuf = NW'(2);
      wr_req  = 1'b1;
      data_ready = 1'b1;
      @(negedge clk);
      chk(cmd_valid && cmd_addr == 8'h0C, "R9", "read first", cmd_addr, 8'h0C);
      do_read(txc + 24'h55, 8'h01, 0);
      poll_rx(rxc + 24'h2);
      send_bufs(2);

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule